// File: doc/BRIEF.md
# TDM Audio Slot Serial Port

This block moves stereo audio samples and two control words over a four-wire time-division serial link. It drives a bit clock, a frame-sync pulse and a transmit line, and it samples a receive line. A frame is a fixed row of 16-bit time slots (eight by default, 128 bit periods in all). Four logical channels each have an enable bit and a 4-bit slot-number field, separately for transmit and receive: left audio, right audio, control word 0 and control word 1. These fields place the channels in the slots in any order.

Each channel and direction has one holding register with a valid/ready handshake. A transmit word waits in its register until its slot begins, then goes out MSB first. A received word lands in its register when its slot ends and stays flagged valid until it is taken. The bit clock runs at half the system clock. A configuration bit selects which bit-clock edge samples the receive line, and transmit data changes on the other edge. A second bit places the sync pulse either one bit period ahead of the first data bit or on it.

Top module: `tdm_slot_port`

## Requirements
- R1: A frame is NUM_SLOTS x SLOT_BITS bit periods (8 x 16 = 128 by default), and `fsync` is high for exactly one bit period per frame. With `sync_dly`=0 the pulse shares its period with bit 15 of slot 0.
- R2: With `sync_dly`=1 the pulse occupies the last bit period of the previous frame, and bit 15 of slot 0 follows in the next period.
- R3: Transmit bits are sent MSB first and change on the bit-clock edge opposite the sampling edge. `rx_edge_rise`=0 samples `rxd` on the falling edge of `sck`, and 1 samples it on the rising edge.
- R4: Channel c (0 left, 1 right, 2 control 0, 3 control 1) uses the transmit slot field `tx_slot[4c+3:4c]` and enable `tx_en[c]`. If the channel is enabled and the field value s is below NUM_SLOTS, its held word goes out in slot s, whatever order the channels take.
- R5: If several enabled transmit channels name the same slot, the lowest channel number uses it and the others keep their words (ready stays low). A field value of NUM_SLOTS or above never matches a slot.
- R6: Transmit data is 0 for a whole slot that has no enabled channel, and for a slot whose channel holds no word when the slot starts.
- R7: `tx_ready[c]` is high exactly when channel c's holding register is empty. A word accepted on `tx_valid[c]` && `tx_ready[c]` moves to the shifter when its slot starts, and ready then returns high.
- R8: For each enabled receive channel whose field `rx_slot[4c+3:4c]` names slot s, the 16 bits sampled in slot s are stored at the end of that slot and `rx_valid[c]` is raised. A disabled channel never raises valid.
- R9: `rx_valid[c]` stays high until a cycle with `rx_ready[c]` high. A new word that arrives before the old one is taken replaces it.
- R10: During reset `sck`, `fsync` and `txd` are 0, every `tx_ready` is 1 and every `rx_valid` is 0. The first bit period after reset is the last period of an empty frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bit clock runs at half this rate |
| rst | input | 1 | Synchronous active-high reset |
| sync_dly | input | 1 | 1: sync pulse one bit period ahead of the first data bit |
| rx_edge_rise | input | 1 | 0: sample rxd on the falling edge of sck; 1: on the rising edge |
| tx_en | input | 4 | Transmit enable per channel |
| tx_slot | input | 16 | Transmit slot number, 4 bits per channel |
| rx_en | input | 4 | Receive enable per channel |
| rx_slot | input | 16 | Receive slot number, 4 bits per channel |
| tx_data | input | 64 | Transmit words, 16 bits per channel |
| tx_valid | input | 4 | Transmit word offered per channel |
| tx_ready | output | 4 | Transmit holding register empty per channel |
| rx_data | output | 64 | Received words, 16 bits per channel |
| rx_valid | output | 4 | Received word present per channel |
| rx_ready | input | 4 | Received word taken per channel |
| sck | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The assertions assume that the slot map, the enables, `sync_dly` and `rx_edge_rise` stay fixed between resets, and that `rxd` is stable for the half bit period before the sampling edge. The bench changes the configuration only while reset is held. It drives `rxd` with the transmit bit in the half period before the chosen sampling edge and with its inverse in the other half, so the data matches only when the correct edge is used. Words are offered only after the last slot of the first frame has started, so the expected slot contents of every frame follow from the map alone.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
   localparam int CH_COUNT = 4;
   typedef enum logic [1:0] {
      CH_LEFT  = 2'd0,
      CH_RIGHT = 2'd1,
      CH_CTL0  = 2'd2,
      CH_CTL1  = 2'd3
   } chan_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int SLOT_BITS = 16,
   parameter int NUM_SLOTS = 8,
   localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS,
   localparam int POS_W = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_dly,
   input  logic             rx_edge_rise,
   output logic             sck,
   output logic             fsync,
   output logic             launch,
   output logic             sample,
   output logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] pos_nxt
);
   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

   logic             ph_q;
   logic             sync_q;
   logic [POS_W-1:0] pos_q;

   assign launch  = (ph_q == rx_edge_rise);
   assign sample  = ~launch;
   assign pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;
   assign sck     = ph_q;
   assign fsync   = sync_q;
   assign pos     = pos_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= 1'b0;
         sync_q <= 1'b0;
         pos_q  <= POS_W'(FRAME_BITS - 2);
      end else begin
         ph_q <= ~ph_q;
         if (launch) begin
            pos_q  <= pos_nxt;
            sync_q <= sync_dly ? (pos_nxt == LAST) : (pos_nxt == '0);
         end
      end
   end

   // R1
   sync_one_period_chk: assert property (@(posedge clk) disable iff (rst)
      (launch && sync_q) |=> !sync_q);

   // R1
   frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (launch && pos_q == LAST) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
   parameter int SLOT_BITS = 16,
   parameter int NUM_SLOTS = 8,
   parameter int FIELD_W   = 4,
   parameter int CH        = 4,
   localparam int POS_W  = $clog2(SLOT_BITS * NUM_SLOTS),
   localparam int IDX_W  = $clog2(SLOT_BITS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   launch,
   input  logic [POS_W-1:0]       pos_nxt,
   input  logic [CH-1:0]          en,
   input  logic [CH*FIELD_W-1:0]  slot_map,
   input  logic [CH*SLOT_BITS-1:0] in_data,
   input  logic [CH-1:0]          in_valid,
   output logic [CH-1:0]          in_ready,
   output logic                   txd
);
   localparam int SLOT_W = POS_W - IDX_W;

   logic [SLOT_W-1:0]    nxt_slot;
   logic                 slot_start;
   logic [CH-1:0]        hit;
   logic [CH-1:0]        sel;
   logic [CH-1:0]        full_q;
   logic [CH-1:0]        load;
   logic [SLOT_BITS-1:0] hold_q [CH];
   logic [SLOT_BITS-1:0] word;
   logic [SLOT_BITS-1:0] sh_q;
   logic                 txd_q;

   assign nxt_slot   = pos_nxt[POS_W-1:IDX_W];
   assign slot_start = (pos_nxt[IDX_W-1:0] == '0);

   always_comb begin
      logic taken;
      taken = 1'b0;
      sel   = '0;
      for (int c = 0; c < CH; c++) begin
         if (hit[c] && !taken) begin
            sel[c] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

   always_comb begin
      word = '0;
      for (int c = 0; c < CH; c++) begin
         if (sel[c] && full_q[c]) word = hold_q[c];
      end
   end

   for (genvar c = 0; c < CH; c++) begin : g_chan
      assign hit[c]      = en[c] && (slot_map[c*FIELD_W +: FIELD_W] == FIELD_W'(nxt_slot));
      assign load[c]     = launch && slot_start && sel[c] && full_q[c];
      assign in_ready[c] = ~full_q[c];

      always_ff @(posedge clk) begin
         if (rst) begin
            full_q[c] <= 1'b0;
            hold_q[c] <= '0;
         end else if (load[c]) begin
            full_q[c] <= 1'b0;
         end else if (in_valid[c] && !full_q[c]) begin
            full_q[c] <= 1'b1;
            hold_q[c] <= in_data[c*SLOT_BITS +: SLOT_BITS];
         end
      end

      // R7
      tx_drain_chk: assert property (@(posedge clk) disable iff (rst)
         $fell(full_q[c]) |-> $past(launch && slot_start));

      // R7
      tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (full_q[c] && !load[c]) |=> (full_q[c] && $stable(hold_q[c])));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         txd_q <= 1'b0;
      end else if (launch) begin
         if (slot_start) begin
            txd_q <= word[SLOT_BITS-1];
            sh_q  <= {word[SLOT_BITS-2:0], 1'b0};
         end else begin
            txd_q <= sh_q[SLOT_BITS-1];
            sh_q  <= {sh_q[SLOT_BITS-2:0], 1'b0};
         end
      end
   end

   assign txd = txd_q;

   // R6
   tx_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (launch && slot_start && !(|(sel & full_q))) |=> !txd_q);
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
   parameter int SLOT_BITS = 16,
   parameter int NUM_SLOTS = 8,
   parameter int FIELD_W   = 4,
   parameter int CH        = 4,
   localparam int POS_W  = $clog2(SLOT_BITS * NUM_SLOTS),
   localparam int IDX_W  = $clog2(SLOT_BITS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    launch,
   input  logic                    sample,
   input  logic [POS_W-1:0]        pos,
   input  logic [POS_W-1:0]        pos_nxt,
   input  logic                    rxd,
   input  logic [CH-1:0]           en,
   input  logic [CH*FIELD_W-1:0]   slot_map,
   input  logic [CH-1:0]           out_ready,
   output logic [CH*SLOT_BITS-1:0] out_data,
   output logic [CH-1:0]           out_valid
);
   localparam int SLOT_W = POS_W - IDX_W;

   logic                 armed_q;
   logic [SLOT_BITS-1:0] sh_q;
   logic [SLOT_BITS-1:0] word;
   logic [SLOT_W-1:0]    cur_slot;
   logic                 slot_end;
   logic [CH-1:0]        cap;
   logic [CH-1:0]        valid_q;

   assign cur_slot = pos[POS_W-1:IDX_W];
   assign slot_end = sample && armed_q && (pos[IDX_W-1:0] == '1);
   assign word     = {sh_q[SLOT_BITS-2:0], rxd};

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         sh_q    <= '0;
      end else begin
         if (launch && pos_nxt == '0) armed_q <= 1'b1;
         if (sample) sh_q <= word;
      end
   end

   for (genvar c = 0; c < CH; c++) begin : g_chan
      assign cap[c] = slot_end && en[c] &&
                      (slot_map[c*FIELD_W +: FIELD_W] == FIELD_W'(cur_slot));

      always_ff @(posedge clk) begin
         if (rst) begin
            valid_q[c]                      <= 1'b0;
            out_data[c*SLOT_BITS +: SLOT_BITS] <= '0;
         end else if (cap[c]) begin
            valid_q[c]                      <= 1'b1;
            out_data[c*SLOT_BITS +: SLOT_BITS] <= word;
         end else if (out_ready[c]) begin
            valid_q[c] <= 1'b0;
         end
      end

      // R8
      rx_latch_at_end_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(valid_q[c]) |-> $past(sample && pos[IDX_W-1:0] == '1));

      // R9
      rx_hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
         (valid_q[c] && !out_ready[c]) |=> valid_q[c]);
   end

   assign out_valid = valid_q;
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
   import tdm_slot_pkg::*;
#(
   parameter int SLOT_BITS = 16,
   parameter int NUM_SLOTS = 8,
   parameter int FIELD_W   = 4,
   localparam int CH    = CH_COUNT,
   localparam int POS_W = $clog2(SLOT_BITS * NUM_SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sync_dly,
   input  logic                    rx_edge_rise,
   input  logic [CH-1:0]           tx_en,
   input  logic [CH*FIELD_W-1:0]   tx_slot,
   input  logic [CH-1:0]           rx_en,
   input  logic [CH*FIELD_W-1:0]   rx_slot,
   input  logic [CH*SLOT_BITS-1:0] tx_data,
   input  logic [CH-1:0]           tx_valid,
   output logic [CH-1:0]           tx_ready,
   output logic [CH*SLOT_BITS-1:0] rx_data,
   output logic [CH-1:0]           rx_valid,
   input  logic [CH-1:0]           rx_ready,
   output logic                    sck,
   output logic                    fsync,
   output logic                    txd,
   input  logic                    rxd
);
   if ((SLOT_BITS < 2) || ((SLOT_BITS & (SLOT_BITS - 1)) != 0)) begin : g_bad_slot_bits
      $error("SLOT_BITS must be a power of two of at least 2");
   end
   if ((NUM_SLOTS < 2) || ((NUM_SLOTS & (NUM_SLOTS - 1)) != 0)) begin : g_bad_num_slots
      $error("NUM_SLOTS must be a power of two of at least 2");
   end
   if (NUM_SLOTS > (1 << FIELD_W)) begin : g_bad_field
      $error("FIELD_W too narrow to name every slot");
   end

   logic             launch;
   logic             sample;
   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] pos_nxt;

   tdm_slot_timer #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_timer (
      .clk(clk), .rst(rst), .sync_dly(sync_dly), .rx_edge_rise(rx_edge_rise),
      .sck(sck), .fsync(fsync), .launch(launch), .sample(sample),
      .pos(pos), .pos_nxt(pos_nxt)
   );

   tdm_tx_path #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .FIELD_W(FIELD_W), .CH(CH)) u_tx (
      .clk(clk), .rst(rst), .launch(launch), .pos_nxt(pos_nxt),
      .en(tx_en), .slot_map(tx_slot), .in_data(tx_data), .in_valid(tx_valid),
      .in_ready(tx_ready), .txd(txd)
   );

   tdm_rx_path #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .FIELD_W(FIELD_W), .CH(CH)) u_rx (
      .clk(clk), .rst(rst), .launch(launch), .sample(sample), .pos(pos),
      .pos_nxt(pos_nxt), .rxd(rxd), .en(rx_en), .slot_map(rx_slot),
      .out_ready(rx_ready), .out_data(rx_data), .out_valid(rx_valid)
   );
endmodule

// File: tb/tdm_slot_port_test.sv
module tdm_slot_port_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sync_dly = 1'b0;
   logic        rx_edge_rise = 1'b0;
   logic [3:0]  tx_en = '0;
   logic [15:0] tx_slot = '0;
   logic [3:0]  rx_en = '0;
   logic [15:0] rx_slot = '0;
   logic [63:0] tx_data = '0;
   logic [3:0]  tx_valid = '0;
   logic [3:0]  tx_ready;
   logic [63:0] rx_data;
   logic [3:0]  rx_valid;
   logic [3:0]  rx_ready = 4'hF;
   logic        sck, fsync, txd, rxd;

   int compared = 0;
   int mismatched = 0;
   int per = -1;
   int run_id = 0;
   bit seen = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // transmit bit in the half period before the sampling edge, inverse in the other half
   assign rxd = (sck == ~rx_edge_rise) ? txd : ~txd;

   tdm_slot_port uut (
      .clk(clk), .rst(rst), .sync_dly(sync_dly), .rx_edge_rise(rx_edge_rise),
      .tx_en(tx_en), .tx_slot(tx_slot), .rx_en(rx_en), .rx_slot(rx_slot),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .sck(sck), .fsync(fsync), .txd(txd), .rxd(rxd)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s run %0d period %0d: actual %h expected %h", tag, run_id, per, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   function automatic logic [15:0] word_of(input int c);
      return {4'(c + 1), 4'(run_id), 8'hA5 ^ 8'(c * 37)};
   endfunction

   // lowest enabled transmit channel naming slot s, or -1
   function automatic int owner(input int s);
      for (int c = 0; c < 4; c++)
         if (tx_en[c] && int'(tx_slot[c*4 +: 4]) == s) return c;
      return -1;
   endfunction

   function automatic logic exp_sync(input int p);
      int pos = (p + 127) % 128;
      return sync_dly ? (pos == 127) : (pos == 0);
   endfunction

   function automatic logic exp_txd(input int p);
      int f   = (p + 127) / 128 - 1;
      int pos = (p + 127) % 128;
      int o   = owner(pos / 16);
      logic [15:0] w;
      if (f != 1 || o < 0) return 1'b0;
      w = word_of(o);
      return w[15 - pos % 16];
   endfunction

   always @(negedge clk) begin
      if (rst) begin
         seen = 1'b0;
         per  = -1;
      end else if (sck != ~rx_edge_rise) begin
         seen = 1'b1;
      end else if (seen) begin
         per = per + 1;
         if (per <= 384) begin
            chk(sync_dly ? "R2" : "R1", 16'(fsync), 16'(exp_sync(per)));
            chk(((per + 127) / 128 == 2) ? "R4" : "R6", 16'(txd), 16'(exp_txd(per)));
         end
      end
   end

   task automatic run_cfg(input int id, input bit dly, input bit edge_r,
                          input logic [3:0] ten, input logic [15:0] tmap,
                          input logic [3:0] ren, input logic [15:0] rmap);
      @(negedge clk);
      rst = 1'b1;
      run_id = id;
      sync_dly = dly;
      rx_edge_rise = edge_r;
      tx_en = ten;
      tx_slot = tmap;
      rx_en = ren;
      rx_slot = rmap;
      tx_valid = '0;
      rx_ready = 4'hF;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", 16'({sck, fsync, txd}), 16'h0);
      chk("R10", 16'(tx_ready), 16'hF);
      chk("R10", 16'(rx_valid), 16'h0);
      rst = 1'b0;

      wait (per == 120);
      @(negedge clk);
      for (int c = 0; c < 4; c++) tx_data[c*16 +: 16] = word_of(c);
      tx_valid = 4'hF;
      @(negedge clk);
      tx_valid = '0;

      wait (per == 132);
      rx_ready = '0;

      wait (per == 262);
      for (int c = 0; c < 4; c++) begin
         int s = int'(rx_slot[c*4 +: 4]);
         int ts = int'(tx_slot[c*4 +: 4]);
         bit v = rx_en[c] && s < 8;
         bit used = (ts < 8) && (owner(ts) == c);
         chk("R8", 16'(rx_valid[c]), 16'(v));
         if (v) chk("R3", rx_data[c*16 +: 16], (owner(s) >= 0) ? word_of(owner(s)) : 16'h0);
         chk(used ? "R7" : "R5", 16'(tx_ready[c]), 16'(used));
      end

      wait (per == 390);
      for (int c = 0; c < 4; c++) begin
         int s = int'(rx_slot[c*4 +: 4]);
         bit v = rx_en[c] && s < 8;
         chk("R9", 16'(rx_valid[c]), 16'(v));
         if (v) chk("R9", rx_data[c*16 +: 16], 16'h0);
      end
   endtask

   initial begin
      // fields packed {ctl1, ctl0, right, left}
      run_cfg(1, 1'b1, 1'b0, 4'hF, 16'h3210, 4'hF, 16'h3210);
      run_cfg(2, 1'b1, 1'b1, 4'hF, 16'h3120, 4'hF, 16'h3120);
      run_cfg(3, 1'b0, 1'b0, 4'hF, 16'h7C50, 4'b1011, 16'h7205);
      run_cfg(4, 1'b0, 1'b1, 4'b1110, 16'h6442, 4'hF, 16'h1264);
      finish_up();
   end

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end
endmodule